// File: doc/BRIEF.md
# SD Host Command Issue Unit

This block lets a processor send commands to an SD card through a small set of memory-mapped registers, and it records the card's answer. Software first writes a 32-bit argument, then writes a 16-bit command word. That word holds a 6-bit command index and flags that say which kind of response is expected. Writing the command word with its launch bit set starts one transaction on an abstract card-side port. The port carries the index and the argument to the card and later returns a byte count together with up to sixteen response bytes, or a failure indication.

When the card answers, the unit checks that the number of returned bytes fits the response type requested. If it does, the bytes are packed into four 32-bit response words. If it does not, or if the card reports a failure, a fail flag is set in the command word and a command-timeout bit is set in a status register. Software clears the status bit by writing a one to it. The serial CMD-line signalling, CRC7 and clock division belong to neighbouring logic. A behavioural card model stands in for them in the testbench.

Top module: `sdcmd_issue`

## Requirements
- R1: After a synchronous active-low reset, the command, argument, response and status registers all read 0, and `busy` and `card_req` are low.
- R2: Register map: command at 0x00, argument at 0x04, response words 0 to 3 at 0x10, 0x14, 0x18 and 0x1C, status at 0x20. Any other offset reads 0. Command bit 15 launches and always reads back 0. Bits 14:0 read back as written. Bits 5:0 are the index, bit 10 means no response and bit 9 means long response. During a command, `card_index` and `card_arg` hold the index and the argument that were current at launch.
- R3: `busy` and `card_req` rise at the clock edge that accepts a launch write. They fall at the first edge where `card_ack` is sampled high. While `busy` is high, a write to the command register changes nothing and does not start another command.
- R4: A valid 4-byte response packs bytes 0..3 into word 0 big-endian: byte 0 goes to bits 31:24 and byte 3 to bits 7:0. Words 1 to 3 become 0. Byte i arrives on `card_data[8*i+7:8*i]`.
- R5: A valid 16-byte response loads word 0 from bytes 12..15, word 1 from bytes 8..11, word 2 from bytes 4..7 and word 3 from bytes 0..3. Each word is packed big-endian.
- R6: When a response is expected (bit 10 clear), the returned length is an error if it is 0, if it is not 4 or 16, or if it is 4 while bit 9 is set.
- R7: A high `card_fail` at acknowledge is an error whatever the response flags are.
- R8: An error sets command bit 14 and status bit 6 and leaves the response words unchanged.
- R9: With bit 10 set and no card failure, no length check is made, no error is raised and the response words keep their contents.
- R10: Writing the status register clears the bits written as 1 and leaves the bits written as 0. If that write falls in the same cycle as an error, bit 6 ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 8 | Write byte offset |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 8 | Read byte offset |
| reg_rdata | output | 32 | Read data, combinational from `reg_raddr` |
| card_req | output | 1 | Command outstanding on the card port |
| card_index | output | 6 | Command index for the card |
| card_arg | output | 32 | Command argument for the card |
| card_ack | input | 1 | Card has answered; sampled while `card_req` is high |
| card_fail | input | 1 | Card reports a failed command with the acknowledge |
| card_len | input | 5 | Number of response bytes returned |
| card_data | input | 128 | Response bytes, byte i in bits 8*i+7:8*i |
| busy | output | 1 | A command is in flight |

## Verification
Two functions can meet in one cycle. A status write that clears bit 6 can land in the same cycle as a failing acknowledge that sets it. A write to the command register can also land while a command is still in flight. The bench drives the status clear and a faulty card answer at the same clock edge, and it expects bit 6 to read 1 afterwards. It also writes a new launch in the middle of a transaction, then checks that the command word is unchanged and that `card_req` never rises again. A behavioural model compares `busy`, `card_req`, the index and the argument every cycle.

// File: rtl/sdci_pkg.sv
// Package: shared constants for the SD command issue unit.
// Assumes byte offsets on an 8-bit register address and 32-bit data.
package sdci_pkg;
    localparam int ADDR_W    = 8;
    localparam int WORD_W    = 32;
    localparam int RSP_WORDS = 4;
    localparam int RSP_BYTES = RSP_WORDS * 4;
    localparam int LEN_W     = $clog2(RSP_BYTES) + 1;
    localparam int IDX_W     = 6;
    localparam int STAT_W    = 11;

    localparam logic [ADDR_W-1:0] OFS_CMD  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_ARG  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_RSP0 = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h20;

    localparam int B_LAUNCH = 15;
    localparam int B_FAIL   = 14;
    localparam int B_NORSP  = 10;
    localparam int B_LONG   = 9;
    localparam int B_TMO    = 6;

    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/sdci_launch.sv
// Module: launch handshake. It holds card_req from an accepted launch
// until card_ack is sampled, and it latches the index and argument for the card.
// Assumes the card keeps card_ack low while no request is outstanding.
module sdci_launch
    import sdci_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic [IDX_W-1:0] idx_in,
    input  word_t            arg_in,
    input  logic             card_ack,
    output logic             busy,
    output logic             done,
    output logic [IDX_W-1:0] card_index,
    output word_t            card_arg
);
    // Completion happens in the cycle the acknowledge is seen while busy
    assign done = busy && card_ack;

    // Busy flag: set on launch, cleared on completion
    always_ff @(posedge clk) begin
        if (!rst_n)      busy <= 1'b0;
        else if (done)   busy <= 1'b0;
        else if (launch) busy <= 1'b1;
    end

    // Capture the index and argument at launch so they stay put during the command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            card_index <= '0;
            card_arg   <= '0;
        end else if (launch && !busy) begin
            card_index <= idx_in;
            card_arg   <= arg_in;
        end
    end

    p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !card_ack |=> busy);
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !launch |=> !busy);
    p_launch_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !card_ack |=> $stable(card_index) && $stable(card_arg));
endmodule

// File: rtl/sdci_rsp_decode.sv
// Module: response checking and packing (combinational).
// It checks the returned length against the requested response type and builds
// four big-endian words, either in short or in reversed long order.
// Assumes byte i of the response is card_data[8*i +: 8].
module sdci_rsp_decode
    import sdci_pkg::*;
(
    input  logic                       no_rsp,
    input  logic                       long_rsp,
    input  logic                       card_fail,
    input  logic [LEN_W-1:0]           card_len,
    input  logic [RSP_BYTES*8-1:0]     card_data,
    output logic                       err,
    output logic [RSP_WORDS-1:0][WORD_W-1:0] words
);
    localparam logic [LEN_W-1:0] LEN_SHORT = LEN_W'(4);
    localparam logic [LEN_W-1:0] LEN_LONG  = LEN_W'(RSP_BYTES);

    logic is_long;
    logic bad_len;

    // Decide whether the response length breaks the rules
    always_comb begin
        is_long = (card_len == LEN_LONG);
        bad_len = (card_len != LEN_SHORT && !is_long) ||
                  (card_len == LEN_SHORT && long_rsp);
        err     = card_fail || (!no_rsp && bad_len);
    end

    // Pack each word from its four bytes, highest address in the low bits
    for (genvar w = 0; w < RSP_WORDS; w++) begin : g_word
        localparam int LBASE = 4 * (RSP_WORDS - 1 - w);
        logic [WORD_W-1:0] long_word;
        logic [WORD_W-1:0] short_word;
        assign long_word = {card_data[8*LBASE +: 8], card_data[8*(LBASE+1) +: 8],
                            card_data[8*(LBASE+2) +: 8], card_data[8*(LBASE+3) +: 8]};
        if (w == 0) begin : g_first
            assign short_word = {card_data[7:0], card_data[15:8],
                                 card_data[23:16], card_data[31:24]};
        end else begin : g_rest
            assign short_word = '0;
        end
        assign words[w] = is_long ? long_word : short_word;
    end
endmodule

// File: rtl/sdcmd_issue.sv
// Module: SD command issue unit, top level.
// It holds the register file (command, argument, response words, status),
// starts commands on the card port and records the outcome.
// Assumes single-cycle register writes and a combinational read path.
module sdcmd_issue
    import sdci_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic [ADDR_W-1:0]      reg_waddr,
    input  logic [WORD_W-1:0]      reg_wdata,
    input  logic [ADDR_W-1:0]      reg_raddr,
    output logic [WORD_W-1:0]      reg_rdata,
    output logic                   card_req,
    output logic [IDX_W-1:0]       card_index,
    output logic [WORD_W-1:0]      card_arg,
    input  logic                   card_ack,
    input  logic                   card_fail,
    input  logic [LEN_W-1:0]       card_len,
    input  logic [RSP_BYTES*8-1:0] card_data,
    output logic                   busy
);
    logic [15:0]                       cmd_q;
    word_t                             arg_q;
    logic [RSP_WORDS-1:0][WORD_W-1:0]  rsp_q;
    logic [STAT_W-1:0]                 stat_q;
    logic [RSP_WORDS-1:0][WORD_W-1:0]  dec_words;
    logic                              dec_err;
    logic                              done;
    logic                              cmd_wr, arg_wr, stat_wr, launch;

    // Decode write strobes for each register
    always_comb begin
        cmd_wr  = reg_wr && (reg_waddr == OFS_CMD);
        arg_wr  = reg_wr && (reg_waddr == OFS_ARG);
        stat_wr = reg_wr && (reg_waddr == OFS_STAT);
        launch  = cmd_wr && reg_wdata[B_LAUNCH] && !busy;
    end

    sdci_launch u_launch (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .idx_in     (reg_wdata[IDX_W-1:0]),
        .arg_in     (arg_q),
        .card_ack   (card_ack),
        .busy       (busy),
        .done       (done),
        .card_index (card_index),
        .card_arg   (card_arg)
    );

    assign card_req = busy;

    sdci_rsp_decode u_decode (
        .no_rsp    (cmd_q[B_NORSP]),
        .long_rsp  (cmd_q[B_LONG]),
        .card_fail (card_fail),
        .card_len  (card_len),
        .card_data (card_data),
        .err       (dec_err),
        .words     (dec_words)
    );

    // Command word: host writes while idle, fail flag set on error, launch bit never kept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else begin
            if (cmd_wr && !busy) cmd_q <= {1'b0, reg_wdata[14:0]};
            if (done && dec_err) cmd_q[B_FAIL] <= 1'b1;
        end
    end

    // Argument register: plain host write
    always_ff @(posedge clk) begin
        if (!rst_n)      arg_q <= '0;
        else if (arg_wr) arg_q <= reg_wdata;
    end

    // Status: write-one-to-clear, with a same-cycle error set taking priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~(stat_wr ? reg_wdata[STAT_W-1:0] : '0))
                    | ((done && dec_err) ? STAT_W'(1 << B_TMO) : '0);
        end
    end

    // Response words: loaded only on a good completion that expects a response
    always_ff @(posedge clk) begin
        if (!rst_n)                                  rsp_q <= '0;
        else if (done && !dec_err && !cmd_q[B_NORSP]) rsp_q <= dec_words;
    end

    // Read multiplexer by byte offset
    always_comb begin
        unique case (reg_raddr)
            OFS_CMD:      reg_rdata = {16'h0, cmd_q};
            OFS_ARG:      reg_rdata = arg_q;
            OFS_RSP0:     reg_rdata = rsp_q[0];
            OFS_RSP0 + 4: reg_rdata = rsp_q[1];
            OFS_RSP0 + 8: reg_rdata = rsp_q[2];
            OFS_RSP0 + 12: reg_rdata = rsp_q[3];
            OFS_STAT:     reg_rdata = {{(WORD_W-STAT_W){1'b0}}, stat_q};
            default:      reg_rdata = '0;
        endcase
    end

    p_fail_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done && dec_err |=> cmd_q[B_FAIL] && stat_q[B_TMO] && $stable(rsp_q));
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done && dec_err && stat_wr |=> stat_q[B_TMO]);
    p_noresp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done && cmd_q[B_NORSP] |=> $stable(rsp_q));
    p_short_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done && !dec_err && !cmd_q[B_NORSP] && card_len == LEN_W'(4)
        |=> rsp_q[1] == '0 && rsp_q[2] == '0 && rsp_q[3] == '0);
endmodule

// File: tb/sdcmd_issue_tb.sv
module sdcmd_issue_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic [7:0]   reg_waddr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [7:0]   reg_raddr = '0;
    logic [31:0]  reg_rdata;
    logic         card_req;
    logic [5:0]   card_index;
    logic [31:0]  card_arg;
    logic         card_ack = 1'b0;
    logic         card_fail = 1'b0;
    logic [4:0]   card_len = '0;
    logic [127:0] card_data = '0;
    logic         busy;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference model state
    logic [15:0] m_cmd = '0;
    logic [31:0] m_arg = '0;
    logic [31:0] m_rsp [4] = '{default: '0};
    logic [10:0] m_stat = '0;
    bit          m_busy = 0;
    logic [5:0]  m_idx = '0;
    logic [31:0] m_larg = '0;

    always #2ns clk = ~clk;

    sdcmd_issue u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .card_req(card_req), .card_index(card_index), .card_arg(card_arg),
        .card_ack(card_ack), .card_fail(card_fail), .card_len(card_len),
        .card_data(card_data), .busy(busy)
    );

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h00: return {16'h0, m_cmd};
            8'h04: return m_arg;
            8'h10: return m_rsp[0];
            8'h14: return m_rsp[1];
            8'h18: return m_rsp[2];
            8'h1C: return m_rsp[3];
            8'h20: return {21'h0, m_stat};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [7:0] byte_at(input int i);
        return card_data[8*i +: 8];
    endfunction

    // per-cycle comparison of handshake outputs (R3, R2)
    always @(posedge clk) begin
        #1ns;
        n_vec++;
        if (busy !== m_busy || card_req !== m_busy) begin
            n_bad++;
            $display("FAIL R3 busy=%0b req=%0b expected %0b at %0t", busy, card_req, m_busy, $time);
        end
        if (m_busy) begin
            n_vec++;
            if (card_index !== m_idx || card_arg !== m_larg) begin
                n_bad++;
                $display("FAIL R2 index=%h arg=%h expected %h %h", card_index, card_arg, m_idx, m_larg);
            end
        end
    end

    // one clock: drive at negedge, model update at posedge, release at next negedge
    task automatic tick(input bit wr, input logic [7:0] a, input logic [31:0] d, input bit ack);
        bit was_busy;
        bit err;
        int len;
        reg_wr = wr; reg_waddr = a; reg_wdata = d; card_ack = ack;
        @(posedge clk);
        was_busy = m_busy;
        if (wr) begin
            if (a == 8'h00 && !was_busy) begin
                m_cmd = {1'b0, d[14:0]};
                if (d[15]) begin
                    m_busy = 1; m_idx = d[5:0]; m_larg = m_arg;
                end
            end else if (a == 8'h04) begin
                m_arg = d;
            end else if (a == 8'h20) begin
                m_stat = m_stat & ~d[10:0];
            end
        end
        if (ack && was_busy) begin
            m_busy = 0;
            len = int'(card_len);
            err = card_fail;
            if (!m_cmd[10]) begin
                if (len == 0) err = 1;
                if (len != 4 && len != 16) err = 1;
                if (len == 4 && m_cmd[9]) err = 1;
            end
            if (err) begin
                m_cmd[14] = 1'b1;
                m_stat[6] = 1'b1;
            end else if (!m_cmd[10]) begin
                for (int w = 0; w < 4; w++) begin
                    int b;
                    b = (len == 16) ? 12 - 4*w : 0;
                    if (len == 4 && w > 0) m_rsp[w] = 32'h0;
                    else m_rsp[w] = {byte_at(b), byte_at(b+1), byte_at(b+2), byte_at(b+3)};
                end
            end
        end
        @(negedge clk);
        reg_wr = 1'b0; card_ack = 1'b0;
    endtask

    task automatic check_rd(input logic [7:0] a, input string tag);
        logic [31:0] e;
        reg_raddr = a;
        #1ns;
        e = m_read(a);
        n_vec++;
        if (reg_rdata !== e) begin
            n_bad++;
            $display("FAIL %s offset %h: got %h expected %h", tag, a, reg_rdata, e);
        end
    endtask

    task automatic check_all(input string tag);
        check_rd(8'h00, tag); check_rd(8'h04, tag);
        check_rd(8'h10, tag); check_rd(8'h14, tag);
        check_rd(8'h18, tag); check_rd(8'h1C, tag);
        check_rd(8'h20, tag);
    endtask

    task automatic set_card(input int len, input logic [7:0] seed, input bit fl);
        card_len = 5'(len);
        card_fail = fl;
        for (int i = 0; i < 16; i++) card_data[8*i +: 8] = seed + 8'(i * 7);
    endtask

    // full command: launch, wait, answer
    task automatic run_cmd(input logic [15:0] c, input int wait_cyc);
        tick(1, 8'h00, {16'h0, c}, 0);
        for (int k = 0; k < wait_cyc; k++) tick(0, 8'h00, 32'h0, 0);
        tick(0, 8'h00, 32'h0, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check_all("R1");

        // R2: argument write and readback, unmapped offset reads 0
        tick(1, 8'h04, 32'hCAFEF00D, 0);
        check_rd(8'h04, "R2");
        check_rd(8'h24, "R2");
        check_rd(8'h0C, "R2");

        // R5: long response, R2 launch bit reads 0 during flight
        set_card(16, 8'hA0, 0);
        tick(1, 8'h00, 32'h0000_8211, 0);
        tick(0, 8'h00, 32'h0, 0);
        check_rd(8'h00, "R2");
        tick(0, 8'h00, 32'h0, 1);
        check_all("R5");

        // R4: short response clears words 1..3
        tick(1, 8'h04, 32'h1234_5678, 0);
        set_card(4, 8'h51, 0);
        run_cmd(16'h800D, 3);
        check_all("R4");

        // R3: launch while busy ignored, no relaunch after completion
        set_card(4, 8'h33, 0);
        tick(1, 8'h00, 32'h0000_8002, 0);
        tick(1, 8'h00, 32'h0000_8409, 0);
        check_rd(8'h00, "R3");
        tick(0, 8'h00, 32'h0, 1);
        tick(0, 8'h00, 32'h0, 0);
        tick(0, 8'h00, 32'h0, 0);
        check_all("R3");

        // R6/R8: zero length with response expected
        set_card(0, 8'h99, 0);
        run_cmd(16'h8001, 1);
        check_all("R6");
        // R10: clear status
        tick(1, 8'h20, 32'h0000_0040, 0);
        check_rd(8'h20, "R10");

        // R6: 4 bytes with long requested
        set_card(4, 8'h77, 0);
        run_cmd(16'h8202, 0);
        check_all("R6");
        // R10: writing zero leaves status bit set
        tick(1, 8'h20, 32'h0, 0);
        check_rd(8'h20, "R10");
        tick(1, 8'h20, 32'h7FF, 0);
        check_rd(8'h20, "R10");

        // R6: illegal length 8 on short response
        set_card(8, 8'h11, 0);
        run_cmd(16'h8003, 2);
        check_all("R6");
        tick(1, 8'h20, 32'h40, 0);

        // R7: card failure with no response requested
        set_card(0, 8'h22, 1);
        run_cmd(16'h8400, 1);
        check_all("R7");
        tick(1, 8'h20, 32'h40, 0);

        // R9: no response, zero length, no error, words kept
        set_card(0, 8'hEE, 0);
        run_cmd(16'h8407, 2);
        check_all("R9");
        set_card(16, 8'h05, 0);
        run_cmd(16'h8408, 1);
        check_all("R9");

        // R10: clear write in the same cycle as a failing acknowledge
        set_card(12, 8'h44, 0);
        tick(1, 8'h00, 32'h0000_8005, 0);
        tick(0, 8'h00, 32'h0, 0);
        tick(1, 8'h20, 32'h0000_0040, 1);
        check_all("R10");

        // R5 again after errors: long with no long flag still packs 16 bytes
        tick(1, 8'h20, 32'h7FF, 0);
        tick(1, 8'h04, 32'h0BAD_BEEF, 0);
        set_card(16, 8'hC3, 0);
        run_cmd(16'h803F, 4);
        check_all("R5");

        // R1: reset returns everything to zero
        rst_n = 1'b0;
        @(posedge clk);
        m_cmd = '0; m_arg = '0; m_stat = '0; m_busy = 0;
        for (int w = 0; w < 4; w++) m_rsp[w] = '0;
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R1");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule